// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a register-array model of a synchronous static memory. Its bus can switch between reads and writes on every clock with no dead cycle in between. Address, command, chip selects and byte enables are taken on the rising clock edge. Write data follows its address on a later edge, so the bus carries read and write data in the same relative slot.

A static mode input picks one of two timings. In flow-through operation, read data comes straight from the array in the cycle after the address edge, and write data is taken one edge after its address. In pipelined operation, read data passes through an output register and appears one cycle later, and write data is taken two edges after its address. In that mode, a read issued directly after a write to the same word receives the newer bytes from the write stage.

A burst advance input continues the previous operation at the next address. It steps through the two low address bits in either linear or interleaved order. An asynchronous output enable can turn the read drive off at any moment.

Top module: `lwsram`

## Requirements
- R1: After reset, `rdrv` is 0 and `rdata` is all zeros until a selected read produces data.
- R2: A non-advance cycle is selected only when `cs_a`, `cs_b` and `cs_c` are all 1. Any other cycle writes nothing and drives nothing.
- R3: With `pipe_mode`=0, data for a read whose address is taken at edge n is driven (`rdrv`=1) between edge n and edge n+1.
- R4: With `pipe_mode`=1, data for a read whose address is taken at edge n is driven between edge n+1 and edge n+2.
- R5: Write data is taken from `wdata` at edge n+1 when `pipe_mode`=0 and at edge n+2 when `pipe_mode`=1, where n is the address edge.
- R6: `byte_en[i]`=1 writes bits [9i+8:9i]. Bytes whose enable is 0 keep their old contents.
- R7: Reads and writes in any order on consecutive clocks all complete correctly. The bus is not driven in any cycle that carries no read data.
- R8: A read taken on the edge right after a write to the same address returns the written bytes, merged byte by byte with the old contents according to the write's enables.
- R9: With `adv`=1 and `burst_ilv`=0, the k-th advance after a start address with low bits b uses low bits (b+k) mod 4. The upper address bits are unchanged.
- R10: With `adv`=1 and `burst_ilv`=1, the k-th advance uses low bits b XOR k.
- R11: An advance cycle ignores `cs_*`, `wr_en`, `byte_en` and `addr`. It repeats the previous cycle's operation and byte enables. If the previous cycle was not selected, the advance cycle is not selected either.
- R12: `oe`=0 forces `rdrv` to 0 and `rdata` to zero at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pipe_mode | input | 1 | 1 = pipelined timing, 0 = flow-through (static) |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c | input | 1 | Chip select, active high |
| adv | input | 1 | Continue the burst at the next address |
| wr_en | input | 1 | 1 = write, 0 = read |
| byte_en | input | 2 | Per-byte write enables |
| addr | input | 8 | Word address |
| wdata | input | 18 | Late write data |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | 18 | Read data, zero when not driven |
| rdrv | output | 1 | Read data drive enable |

## Verification
The embedded assertions check these rules on every cycle:
- a deselected or orphan-advance cycle becomes idle;
- a linear advance steps the low address bits by one and keeps the upper bits;
- the pipelined output register is valid exactly after a read;
- a full-word write is forwarded to a read that follows it directly.

Only the bench scenarios can show the following:
- the end-to-end read and late-write latencies in both modes;
- per-byte merging in the array and in the forward path;
- interleaved ordering and bursts of writes;
- mixed read/write streams on consecutive clocks;
- the asynchronous effect of the output enable.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits of a burst beat
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/lwsram_cmd.sv
module lwsram_cmd
  import lwsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_all,
  input  logic          adv,
  input  logic          wr,
  input  logic          ilv,
  input  logic [NB-1:0] be,
  input  logic [AW-1:0] addr,
  output op_e           op_q,
  output logic [AW-1:0] addr_q,
  output logic [NB-1:0] be_q
);

  logic [AW-1:0] base_q, base_d, addr_d;
  logic [1:0]    cnt_q, cnt_d, cnt_nx;
  logic [NB-1:0] be_d;
  op_e           op_d;

  assign cnt_nx = cnt_q + 2'd1;

  always_comb begin
    op_d   = OP_IDLE;
    addr_d = addr_q;
    be_d   = be_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (adv) begin
      if (op_q != OP_IDLE) begin
        op_d   = op_q;
        cnt_d  = cnt_nx;
        addr_d = {base_q[AW-1:2], burst_lo(base_q[1:0], cnt_nx, ilv)};
      end
    end else if (ce_all) begin
      op_d   = wr ? OP_WRITE : OP_READ;
      addr_d = addr;
      base_d = addr;
      cnt_d  = 2'd0;
      be_d   = be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      be_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      be_q   <= be_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_all && !adv) |=> (op_q == OP_IDLE));

  assert_orphan_adv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && op_q == OP_IDLE) |=> (op_q == OP_IDLE));

  assert_linear_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && op_q != OP_IDLE && !ilv) |=>
      (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1) &&
      (addr_q[AW-1:2] == $past(addr_q[AW-1:2])));

endmodule

// File: rtl/lwsram_mem.sv
module lwsram_mem #(
  parameter int NB    = 2,
  parameter int BW    = 9,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  localparam int DW   = NB * BW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [NB-1:0] wbe,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[b]) lane[waddr] <= wdata[b*BW +: BW];
    end

    assign rdata[b*BW +: BW] = lane[raddr];
  end

endmodule

// File: rtl/lwsram_rdpath.sv
module lwsram_rdpath #(
  parameter int NB = 2,
  parameter int BW = 9,
  parameter int AW = 8,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe,
  input  logic          s1_rd,
  input  logic [AW-1:0] s1_addr,
  input  logic [DW-1:0] arr_data,
  input  logic          s2_wr,
  input  logic [AW-1:0] s2_addr,
  input  logic [NB-1:0] s2_be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dout_q,
  output logic          dvalid_q
);

  logic          hit;
  logic [DW-1:0] fwd, dout_d;
  logic          dvalid_d;

  assign hit = s2_wr && (s2_addr == s1_addr);

  for (genvar b = 0; b < NB; b++) begin : g_fwd
    assign fwd[b*BW +: BW] = (hit && s2_be[b]) ? wdata[b*BW +: BW]
                                               : arr_data[b*BW +: BW];
  end

  always_comb begin
    dvalid_d = pipe && s1_rd;
    dout_d   = dout_q;
    if (pipe && s1_rd) dout_d = fwd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvalid_q <= 1'b0;
      dout_q   <= '0;
    end else begin
      dvalid_q <= dvalid_d;
      dout_q   <= dout_d;
    end
  end

  assert_outreg_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && s1_rd) |=> dvalid_q);

  assert_forward_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && s1_rd && s2_wr && s2_addr == s1_addr && (&s2_be))
      |=> (dout_q == $past(wdata)));

endmodule

// File: rtl/lwsram.sv
module lwsram
  import lwsram_pkg::*;
#(
  parameter int NB    = 2,
  parameter int BW    = 9,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  logic          burst_ilv,
  input  logic          cs_a,
  input  logic          cs_b,
  input  logic          cs_c,
  input  logic          adv,
  input  logic          wr_en,
  input  logic [NB-1:0] byte_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          oe,
  output logic [DW-1:0] rdata,
  output logic          rdrv
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  // stage 1: captured command
  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  logic [NB-1:0] s1_be;

  lwsram_cmd #(.AW(AW), .NB(NB)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .ce_all (cs_a & cs_b & cs_c),
    .adv    (adv),
    .wr     (wr_en),
    .ilv    (burst_ilv),
    .be     (byte_en),
    .addr   (addr),
    .op_q   (s1_op),
    .addr_q (s1_addr),
    .be_q   (s1_be)
  );

  // stage 2: pending write (pipelined mode)
  op_e           s2_op, s2_op_d;
  logic [AW-1:0] s2_addr, s2_addr_d;
  logic [NB-1:0] s2_be, s2_be_d;

  always_comb begin
    s2_op_d   = s1_op;
    s2_addr_d = s1_addr;
    s2_be_d   = s1_be;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else begin
      s2_op   <= s2_op_d;
      s2_addr <= s2_addr_d;
      s2_be   <= s2_be_d;
    end
  end

  // write commit when data arrives
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [NB-1:0] mem_wbe;
  logic [DW-1:0] arr_data;

  always_comb begin
    if (pipe_mode) begin
      mem_we    = (s2_op == OP_WRITE);
      mem_waddr = s2_addr;
      mem_wbe   = s2_be;
    end else begin
      mem_we    = (s1_op == OP_WRITE);
      mem_waddr = s1_addr;
      mem_wbe   = s1_be;
    end
  end

  lwsram_mem #(.NB(NB), .BW(BW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wbe   (mem_wbe),
    .wdata (wdata),
    .raddr (s1_addr),
    .rdata (arr_data)
  );

  logic [DW-1:0] dout_q;
  logic          dvalid_q;

  lwsram_rdpath #(.NB(NB), .BW(BW), .AW(AW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .pipe     (pipe_mode),
    .s1_rd    (s1_op == OP_READ),
    .s1_addr  (s1_addr),
    .arr_data (arr_data),
    .s2_wr    (s2_op == OP_WRITE),
    .s2_addr  (s2_addr),
    .s2_be    (s2_be),
    .wdata    (wdata),
    .dout_q   (dout_q),
    .dvalid_q (dvalid_q)
  );

  // output select with asynchronous enable
  logic drv_int;
  assign drv_int = pipe_mode ? dvalid_q : (s1_op == OP_READ);
  assign rdrv    = oe & drv_int;
  assign rdata   = rdrv ? (pipe_mode ? dout_q : arr_data) : '0;

endmodule

// File: tb/lwsram_test.sv
module lwsram_test;
  localparam int NB = 2, BW = 9, DEPTH = 256, AW = 8, DW = NB * BW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, pipe_mode, burst_ilv, cs_a, cs_b, cs_c, adv, wr_en, oe;
  logic [NB-1:0] byte_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rdrv;

  lwsram #(.NB(NB), .BW(BW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c), .adv(adv), .wr_en(wr_en),
    .byte_en(byte_en), .addr(addr), .wdata(wdata), .oe(oe),
    .rdata(rdata), .rdrv(rdrv)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] wd_at [int];
  int            q_due [$];
  logic [DW-1:0] q_val [$];
  string         q_tag [$];
  bit            mon_on = 0;
  int            bop = 0;
  logic [AW-1:0] bbase = '0;
  logic [1:0]    bcnt = '0;
  logic [NB-1:0] bbe = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'(a * 1031 + s * 77 + 3);
  endfunction

  // monitor: pops expected read data when due, else bus must be idle
  always @(negedge clk) begin
    if (mon_on) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        string t;
        logic [DW-1:0] v;
        t = q_tag.pop_front();
        v = q_val.pop_front();
        void'(q_due.pop_front());
        if (oe) begin
          chk({t, " drive"}, 32'(rdrv), 32'd1);
          chk({t, " data"}, 32'(rdata), 32'(v));
        end else begin
          chk({t, " R12 drive off"}, 32'(rdrv), 32'd0);
          chk({t, " R12 data zero"}, 32'(rdata), 32'd0);
        end
      end else begin
        chk("R7 idle bus", 32'(rdrv), 32'd0);
      end
    end
  end

  // driver: one bus cycle; pushes expected reads, schedules late data
  task automatic drive(input logic [2:0] ce, input bit a, input bit w,
                       input logic [NB-1:0] b, input logic [AW-1:0] ad,
                       input logic [DW-1:0] d, input string tag);
    int            op, n;
    logic [AW-1:0] eff;
    logic [NB-1:0] be_eff;
    n = cyc + 1;
    op = 0; eff = ad; be_eff = b;
    if (a) begin
      if (bop != 0) begin
        op = bop;
        bcnt = bcnt + 2'd1;
        eff = {bbase[AW-1:2], burst_ilv ? (bbase[1:0] ^ bcnt) : (bbase[1:0] + bcnt)};
        be_eff = bbe;
      end
    end else if (ce == 3'b111) begin
      op = w ? 2 : 1;
      bbase = ad; bcnt = 2'd0; bbe = b;
    end
    bop = op;
    cs_a = ce[0]; cs_b = ce[1]; cs_c = ce[2];
    adv = a; wr_en = w; byte_en = b; addr = ad;
    wdata = wd_at.exists(n) ? wd_at[n] : 18'h15a5a;
    if (op == 2) begin
      for (int i = 0; i < NB; i++)
        if (be_eff[i]) model[eff][i*BW +: BW] = d[i*BW +: BW];
      wd_at[n + (pipe_mode ? 2 : 1)] = d;
    end else if (op == 1) begin
      q_due.push_back(n + (pipe_mode ? 1 : 0));
      q_val.push_back(model[eff]);
      q_tag.push_back(tag);
    end
    @(posedge clk); #2;
  endtask

  task automatic nop();
    drive(3'b000, 0, 0, '0, '0, '0, "");
  endtask
  task automatic wr(input logic [AW-1:0] ad, input logic [DW-1:0] d,
                    input logic [NB-1:0] b, input string tag);
    drive(3'b111, 0, 1, b, ad, d, tag);
  endtask
  task automatic rd(input logic [AW-1:0] ad, input string tag);
    drive(3'b111, 0, 0, '0, ad, '0, tag);
  endtask
  task automatic advc(input logic [DW-1:0] d, input string tag);
    drive(3'b000, 1, 0, '0, 8'hff, d, tag);
  endtask

  task automatic run_mode(input bit p);
    rst_n = 1'b0; pipe_mode = p; burst_ilv = 1'b0; oe = 1'b1;
    bop = 0;
    nop(); nop();
    rst_n = 1'b1;
    nop(); nop(); nop();
    @(negedge clk);
    chk("R1 reset drive", 32'(rdrv), 32'd0);
    chk("R1 reset data", 32'(rdata), 32'd0);
    @(posedge clk); #2;
    mon_on = 1;

    for (int a = 0; a < 8; a++) wr(AW'(a), pat(a, p), 2'b11, "");
    for (int a = 16; a < 20; a++) wr(AW'(a), pat(a, p), 2'b11, "");
    for (int a = 32; a < 36; a++) wr(AW'(a), pat(a, p), 2'b11, "");
    nop(); nop(); nop();
    rd(8'd0, "R5 late write data");
    rd(8'd3, p ? "R4 pipelined read latency" : "R3 flow-through read latency");
    nop(); nop();

    rd(8'd1, "R7 b2b read");
    wr(8'd2, pat(2, 9), 2'b11, "");
    rd(8'd2, "R8 read right after write");
    wr(8'd3, pat(3, 9), 2'b11, "");
    rd(8'd3, "R7 b2b tail read");
    nop(); nop();

    wr(8'd4, pat(4, 11), 2'b01, "");
    nop(); nop();
    rd(8'd4, "R6 low byte only");
    wr(8'd5, pat(5, 12), 2'b10, "");
    rd(8'd5, "R8 per-byte forward");
    nop(); nop();

    drive(3'b110, 0, 1, 2'b11, 8'd6, pat(6, 20), "");
    drive(3'b101, 0, 1, 2'b11, 8'd7, pat(7, 20), "");
    drive(3'b011, 0, 1, 2'b11, 8'd7, pat(7, 21), "");
    nop(); nop();
    rd(8'd6, "R2 deselected write ignored");
    rd(8'd7, "R2 deselected write ignored");
    drive(3'b011, 0, 0, '0, 8'd1, '0, "");
    nop(); nop();

    rd(8'd18, "R9 linear start");
    advc('0, "R9 linear beat");
    advc('0, "R9 linear beat");
    advc('0, "R9 linear wrap beat");
    wr(8'd34, pat(34, 30), 2'b11, "");
    advc(pat(35, 30), "");
    advc(pat(32, 30), "");
    advc(pat(33, 30), "");
    nop(); nop();
    for (int a = 32; a < 36; a++) rd(AW'(a), "R11 write burst continued");
    nop(); nop();

    burst_ilv = 1'b1;
    rd(8'd17, "R10 interleave start");
    advc('0, "R10 interleave beat");
    advc('0, "R10 interleave beat");
    advc('0, "R10 interleave beat");
    nop(); nop();

    drive(3'b111, 1, 1, 2'b11, 8'd6, pat(6, 40), "");
    nop(); nop();
    rd(8'd6, "R11 orphan advance ignored");
    nop(); nop();

    oe = 1'b0;
    rd(8'd1, "R12 oe low");
    nop(); nop();
    oe = 1'b1;
    nop(); nop(); nop();
    mon_on = 0;
    chk("R7 all reads returned", 32'(q_due.size()), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pipe_mode = 1'b0; burst_ilv = 1'b0; oe = 1'b1;
    cs_a = 0; cs_b = 0; cs_c = 0; adv = 0; wr_en = 0;
    byte_en = '0; addr = '0; wdata = '0;
    @(posedge clk); #2;
    run_mode(1'b0);
    run_mode(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule